// File: doc/BRIEF.md
# Carrier Sense and Digital Loopback Controller

This block produces the registered carrier sense indication of a 10BASE-T transceiver. It also steers the input of the receive path. A receive frame opens when a valid preamble is reported while the receive medium is active. It closes on an end-of-frame pulse, or as soon as receive activity drops. In half duplex, transmit activity also raises carrier sense. In full duplex, only an open receive frame does.

A digital loopback request routes the encoded transmit symbols into the receive path in place of the line symbols. It then forces the symbols sent towards the line to idle and raises a media-disconnect flag. The MII loopback request takes priority over it: while that bit is set, the digital path stays off. The symbol streams are free-running, with one symbol per clock. They carry no valid/ready handshake, and the block never applies back-pressure: a symbol presented in a cycle is routed in that same cycle.

Top module: `crs_lpbk_top`

## Requirements
- R1: During and right after reset, carrier_sense is 0, media_disconnect is 0, rx_path_sym equals line_rx_sym and tx_line_sym equals tx_sym.
- R2: A preamble_ok pulse sampled while rx_active is 1 and frame_end is 0 opens a receive frame. carrier_sense is 1 from the next clock edge, in either duplex mode.
- R3: A frame_end pulse closes the receive frame at the next edge. It wins over a preamble_ok in the same cycle. carrier_sense then drops unless half duplex with tx_active applies.
- R4: A receive frame also closes at the next edge whenever rx_active is sampled 0.
- R5: preamble_ok sampled while rx_active is 0 has no effect, so carrier_sense stays 0 in full duplex.
- R6: In half duplex (full_duplex=0), tx_active sampled 1 makes carrier_sense 1 at the next edge.
- R7: In full duplex (full_duplex=1), tx_active has no effect on carrier_sense.
- R8: dig_loop_req=1 with mii_loop_req=0 sampled at an edge sets media_disconnect to 1 from that edge. While media_disconnect is 1, rx_path_sym equals tx_sym and tx_line_sym is all zeros.
- R9: While mii_loop_req is sampled 1, media_disconnect is 0 at the next edge, whatever dig_loop_req is.
- R10: While media_disconnect is 0, rx_path_sym equals line_rx_sym and tx_line_sym equals tx_sym in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_active | input | 1 | Transmit medium active |
| rx_active | input | 1 | Receive medium active |
| preamble_ok | input | 1 | Single-cycle pulse: valid preamble detected |
| frame_end | input | 1 | Single-cycle pulse: end of frame received |
| full_duplex | input | 1 | 1 = full duplex, 0 = half duplex |
| dig_loop_req | input | 1 | Digital loopback request |
| mii_loop_req | input | 1 | MII loopback request (overrides digital loopback) |
| tx_sym | input | SYM_W | Encoded, filtered transmit symbol |
| line_rx_sym | input | SYM_W | Symbol received from the line |
| rx_path_sym | output | SYM_W | Symbol fed to the receive path |
| tx_line_sym | output | SYM_W | Symbol sent towards the line |
| media_disconnect | output | 1 | Line disconnected for digital loopback |
| carrier_sense | output | 1 | Registered carrier sense |

## Verification
The bench sweeps every combination of the control inputs and single-bit symbols. It runs them once in counting order and once in a scrambled order, so each combination meets both an open and a closed receive frame. The corner cases it targets include the following. A preamble and a frame end in the same cycle: a design where the preamble wins would leave carrier stuck high. Receive activity lost mid-frame: a design that ignores it keeps carrier high until a frame end that may never come. Transmit activity in full duplex: a wrong design raises carrier while only sending. Both loopback bits set: a wrong priority disconnects the media and feeds transmit symbols back during an MII loopback.

// File: rtl/crs_lpbk_pkg.sv
package crs_lpbk_pkg;
  typedef enum logic [1:0] {
    LB_OFF = 2'd0,
    LB_MII = 2'd1,
    LB_DIG = 2'd2
  } lb_mode_e;

  function automatic lb_mode_e lb_decode(input logic dig, input logic mii);
    if (mii)      return LB_MII;
    else if (dig) return LB_DIG;
    else          return LB_OFF;
  endfunction
endpackage

// File: rtl/crs_frame_track.sv
module crs_frame_track (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_active,
  input  logic preamble_ok,
  input  logic frame_end,
  output logic frame_open_nxt,
  output logic frame_open
);
  // frame_end and loss of activity close; preamble opens only with activity
  always_comb begin
    frame_open_nxt = frame_open;
    if (preamble_ok && rx_active) frame_open_nxt = 1'b1;
    if (frame_end || !rx_active)  frame_open_nxt = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) frame_open <= 1'b0;
    else        frame_open <= frame_open_nxt;
  end
endmodule

// File: rtl/crs_gen.sv
module crs_gen (
  input  logic clk,
  input  logic rst_n,
  input  logic full_duplex,
  input  logic tx_active,
  input  logic frame_open_nxt,
  output logic carrier_sense
);
  logic crs_d;

  always_comb begin
    if (full_duplex) crs_d = frame_open_nxt;
    else             crs_d = frame_open_nxt | tx_active;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) carrier_sense <= 1'b0;
    else        carrier_sense <= crs_d;
  end
endmodule

// File: rtl/lpbk_ctrl.sv
module lpbk_ctrl
  import crs_lpbk_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     dig_loop_req,
  input  logic     mii_loop_req,
  output lb_mode_e mode_q,
  output logic     dig_path_on
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= LB_OFF;
    else        mode_q <= lb_decode(dig_loop_req, mii_loop_req);
  end

  assign dig_path_on = (mode_q == LB_DIG);
endmodule

// File: rtl/sym_steer.sv
module sym_steer #(
  parameter int SYM_W = 1
) (
  input  logic             loop_on,
  input  logic [SYM_W-1:0] tx_sym,
  input  logic [SYM_W-1:0] line_rx_sym,
  output logic [SYM_W-1:0] rx_path_sym,
  output logic [SYM_W-1:0] tx_line_sym
);
  for (genvar b = 0; b < SYM_W; b++) begin : g_bit
    assign rx_path_sym[b] = loop_on ? tx_sym[b] : line_rx_sym[b];
    assign tx_line_sym[b] = tx_sym[b] & ~loop_on;
  end
endmodule

// File: rtl/crs_lpbk_top.sv
module crs_lpbk_top
  import crs_lpbk_pkg::*;
#(
  parameter int SYM_W = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tx_active,
  input  logic             rx_active,
  input  logic             preamble_ok,
  input  logic             frame_end,
  input  logic             full_duplex,
  input  logic             dig_loop_req,
  input  logic             mii_loop_req,
  input  logic [SYM_W-1:0] tx_sym,
  input  logic [SYM_W-1:0] line_rx_sym,
  output logic [SYM_W-1:0] rx_path_sym,
  output logic [SYM_W-1:0] tx_line_sym,
  output logic             media_disconnect,
  output logic             carrier_sense
);
  logic     frame_open_nxt;
  logic     frame_open;
  lb_mode_e mode_q;
  logic     dig_on;

  crs_frame_track u_track (
    .clk(clk), .rst_n(rst_n), .rx_active(rx_active),
    .preamble_ok(preamble_ok), .frame_end(frame_end),
    .frame_open_nxt(frame_open_nxt), .frame_open(frame_open)
  );

  crs_gen u_crs (
    .clk(clk), .rst_n(rst_n), .full_duplex(full_duplex),
    .tx_active(tx_active), .frame_open_nxt(frame_open_nxt),
    .carrier_sense(carrier_sense)
  );

  lpbk_ctrl u_lp (
    .clk(clk), .rst_n(rst_n), .dig_loop_req(dig_loop_req),
    .mii_loop_req(mii_loop_req), .mode_q(mode_q), .dig_path_on(dig_on)
  );

  sym_steer #(.SYM_W(SYM_W)) u_steer (
    .loop_on(dig_on), .tx_sym(tx_sym), .line_rx_sym(line_rx_sym),
    .rx_path_sym(rx_path_sym), .tx_line_sym(tx_line_sym)
  );

  assign media_disconnect = dig_on;
endmodule

// File: rtl/crs_lpbk_chk.sv
module crs_lpbk_chk #(
  parameter int SYM_W = 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tx_active,
  input logic             rx_active,
  input logic             preamble_ok,
  input logic             frame_end,
  input logic             full_duplex,
  input logic             dig_loop_req,
  input logic             mii_loop_req,
  input logic [SYM_W-1:0] tx_sym,
  input logic [SYM_W-1:0] line_rx_sym,
  input logic [SYM_W-1:0] rx_path_sym,
  input logic [SYM_W-1:0] tx_line_sym,
  input logic             media_disconnect,
  input logic             carrier_sense
);
  a_r2_preamble_opens: assert property (@(posedge clk) disable iff (!rst_n)
    (preamble_ok && rx_active && !frame_end) |=> carrier_sense);

  a_r3_end_closes: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_end && full_duplex) |=> !carrier_sense);

  a_r4_activity_loss: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_active && full_duplex) |=> !carrier_sense);

  a_r6_half_tx: assert property (@(posedge clk) disable iff (!rst_n)
    (!full_duplex && tx_active) |=> carrier_sense);

  a_r8_disconnect: assert property (@(posedge clk) disable iff (!rst_n)
    (dig_loop_req && !mii_loop_req) |=> media_disconnect);

  a_r8_loop_route: assert property (@(posedge clk) disable iff (!rst_n)
    media_disconnect |-> (rx_path_sym == tx_sym && tx_line_sym == '0));

  a_r9_mii_priority: assert property (@(posedge clk) disable iff (!rst_n)
    mii_loop_req |=> !media_disconnect);

  a_r10_normal_route: assert property (@(posedge clk) disable iff (!rst_n)
    !media_disconnect |-> (rx_path_sym == line_rx_sym && tx_line_sym == tx_sym));
endmodule

bind crs_lpbk_top crs_lpbk_chk #(.SYM_W(SYM_W)) u_chk (.*);

// File: tb/sim_crs_lpbk_top.sv
module sim_crs_lpbk_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tx_active = 0, rx_active = 0, preamble_ok = 0, frame_end = 0;
  logic full_duplex = 0, dig_loop_req = 0, mii_loop_req = 0;
  logic [0:0] tx_sym = '0, line_rx_sym = '0;
  logic [0:0] rx_path_sym, tx_line_sym;
  logic media_disconnect, carrier_sense;

  int compared = 0;
  int mismatched = 0;
  bit done = 0;

  // bench model state
  bit m_frame = 0, m_crs = 0, m_lb = 0;

  always #2.5 clk = ~clk;

  crs_lpbk_top #(.SYM_W(1)) u0 (
    .clk(clk), .rst_n(rst_n), .tx_active(tx_active), .rx_active(rx_active),
    .preamble_ok(preamble_ok), .frame_end(frame_end), .full_duplex(full_duplex),
    .dig_loop_req(dig_loop_req), .mii_loop_req(mii_loop_req),
    .tx_sym(tx_sym), .line_rx_sym(line_rx_sym), .rx_path_sym(rx_path_sym),
    .tx_line_sym(tx_line_sym), .media_disconnect(media_disconnect),
    .carrier_sense(carrier_sense)
  );

  task automatic check(input string req, input logic act, input logic exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic check_all(input string tag);
    check({tag, " R2/R3/R4/R5/R6/R7 carrier_sense"}, carrier_sense, m_crs);
    check({tag, " R8/R9 media_disconnect"}, media_disconnect, m_lb);
    check({tag, " R8/R10 rx_path_sym"}, rx_path_sym[0], m_lb ? tx_sym[0] : line_rx_sym[0]);
    check({tag, " R8/R10 tx_line_sym"}, tx_line_sym[0], m_lb ? 1'b0 : tx_sym[0]);
  endtask

  // drive at negedge, step model, check at next negedge
  task automatic apply(input logic [8:0] v, input string tag);
    {preamble_ok, frame_end, rx_active, tx_active, full_duplex,
     dig_loop_req, mii_loop_req, tx_sym[0], line_rx_sym[0]} = v;
    @(posedge clk);
    m_frame = rx_active && !frame_end && (preamble_ok || m_frame);
    m_crs   = m_frame || (!full_duplex && tx_active);
    m_lb    = dig_loop_req && !mii_loop_req;
    @(negedge clk);
    check_all(tag);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 carrier_sense", carrier_sense, 1'b0);
    check("R1 media_disconnect", media_disconnect, 1'b0);
    line_rx_sym = 1'b1; tx_sym = 1'b1; #1;
    check("R1 rx_path_sym", rx_path_sym[0], 1'b1);
    check("R1 tx_line_sym", tx_line_sym[0], 1'b1);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release", carrier_sense, 1'b0);

    // directed: fields {pre,end,rxa,txa,fd,dig,mii,tx,line}
    apply(9'b1_0_1_0_1_0_0_0_0, "R2 open fd");
    apply(9'b0_0_1_0_1_0_0_0_0, "R2 held");
    apply(9'b0_1_1_0_1_0_0_0_0, "R3 end");
    apply(9'b1_1_1_0_1_0_0_0_0, "R3 end beats preamble");
    apply(9'b1_0_0_0_1_0_0_0_0, "R5 no activity");
    apply(9'b1_0_1_0_1_0_0_0_0, "R4 reopen");
    apply(9'b0_0_0_0_1_0_0_0_0, "R4 activity lost");
    apply(9'b0_0_0_1_1_0_0_0_0, "R7 fd tx");
    apply(9'b0_0_0_1_0_0_0_0_0, "R6 hd tx");
    apply(9'b0_0_0_0_0_1_0_1_0, "R8 loop on");
    apply(9'b0_0_0_0_0_1_1_1_0, "R9 both set");
    apply(9'b0_0_0_0_0_0_0_0_1, "R10 normal");

    // exhaustive sweep in counting order, then scrambled order
    for (int i = 0; i < 512; i++) apply(i[8:0], "sweep");
    for (int i = 0; i < 512; i++) apply(9'((i * 173 + 91) % 512), "scram");

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule